// File: doc/BRIEF.md
# E1 Receive Loss-of-Signal Detector

This block watches the recovered bipolar data of one E1 receive channel. It takes one bit per strobe of the recovered clock, and it raises a loss-of-signal alarm when the line has gone quiet for too long. A bit counts as a mark when either polarity rail is high. The alarm is raised after a fixed run of zero bits. It drops again only after the line shows enough marks over fixed-length windows, with no long zero run inside those windows.

The channel's LOS output is the OR of four things: the digital alarm, an analog low-level flag from the front end, channel power-down and master-clock loss. No interrupt mask acts on it.

While LOS is high the registered receive outputs are held low: positive rail, negative rail and recovered-clock strobe. A data-hold input overrides this, so that data keeps flowing during an alarm. Reset puts the alarm into the lost state and clears the receive outputs.

Top module: `e1_los_detector`

## Requirements
- R1: After 175 consecutive strobed zero bits, `los_o` is high from the clock edge that samples the 175th zero; after 174 zeros it is still low.
- R2: A strobed mark restarts the zero-run count. Two runs of 174 zeros separated by one mark do not raise the alarm.
- R3: While the digital alarm is set, strobed bits are grouped into consecutive 32-bit windows. The first window starts at the first strobed bit after the alarm was set or after reset. The alarm clears on the edge that samples the last bit of a window that holds at least 4 marks and in which no zero run reached 100. After only 31 bits of such a window, the alarm is still set.
- R4: A window with only 3 marks does not clear the alarm.
- R5: A window in which the running zero count reaches 100 or more on any zero bit does not clear the alarm, even when it holds 4 or more marks.
- R6: `los_o` goes high in the same cycle that `alos_i` is high, whatever the state of the digital alarm.
- R7: `pwr_down_i` or `mclk_lost_i` high forces `los_o` high in the same cycle.
- R8: While `rst` is high at a clock edge, the digital alarm is set (`los_o` high) and `rx_pos_o`, `rx_neg_o` and `rx_stb_o` are low after that edge.
- R9: When `los_o` is high and `rx_hold_i` is low at an edge, all three receive outputs are low after that edge.
- R10: Otherwise, after each edge `rx_stb_o` equals the sampled `bit_vld`, and `rx_pos_o` and `rx_neg_o` equal the sampled rails ANDed with `bit_vld`. This includes the case where `rx_hold_i` is high during an alarm.
- R11: A mark on the negative rail alone counts as a mark, the same as one on the positive rail.
- R12: Cycles with `bit_vld` low change neither the zero-run count nor the window state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | One recovered bit is present this cycle |
| rx_pos_i | input | 1 | Recovered positive-rail mark |
| rx_neg_i | input | 1 | Recovered negative-rail mark |
| alos_i | input | 1 | Analog low-input-level flag |
| pwr_down_i | input | 1 | Channel power-down |
| mclk_lost_i | input | 1 | Master clock lost |
| rx_hold_i | input | 1 | Keep receive outputs live during an alarm |
| los_o | output | 1 | Loss-of-signal indication |
| rx_pos_o | output | 1 | Registered positive-rail output |
| rx_neg_o | output | 1 | Registered negative-rail output |
| rx_stb_o | output | 1 | Registered recovered-bit strobe |

## Verification
Two events can land in the same cycle: the digital alarm clearing on a passing window's last bit, and the analog flag holding LOS high. The bench raises `alos_i` across a clearing window. It then checks that `los_o` stays high after the last bit, and that it falls as soon as the flag is dropped, which shows that the digital alarm cleared underneath. A zero-run overflow on the first bit of an otherwise dense window is also driven, to show that the zero-run limit and the density count are judged together.

// File: rtl/e1los_pkg.sv
package e1los_pkg;

    localparam int unsigned DEF_SET_RUN = 175;
    localparam int unsigned DEF_CLR_RUN = 100;
    localparam int unsigned DEF_WIN_LEN = 32;
    localparam int unsigned DEF_WIN_MIN = 4;

    typedef enum logic {
        LINK_OK   = 1'b0,
        LINK_LOST = 1'b1
    } link_e;

    typedef struct packed {
        logic pos;
        logic neg;
        logic stb;
    } rx_sym_t;

    function automatic int unsigned cnt_w(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

    function automatic rx_sym_t sym_idle();
        rx_sym_t s;
        s.pos = 1'b0;
        s.neg = 1'b0;
        s.stb = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/e1los_zero_run.sv
module e1los_zero_run
    import e1los_pkg::*;
#(
    parameter int unsigned SET_RUN = DEF_SET_RUN,
    parameter int unsigned CLR_RUN = DEF_CLR_RUN
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic mark,
    output logic set_hit,
    output logic long_run
);
    localparam int unsigned ZW = cnt_w(SET_RUN);
    localparam logic [ZW-1:0] SET_LAST = ZW'(SET_RUN - 1);
    localparam logic [ZW-1:0] CLR_LAST = ZW'(CLR_RUN - 1);
    localparam logic [ZW-1:0] SAT_VAL  = ZW'(SET_RUN);

    logic [ZW-1:0] zrun_q;
    logic          zero_bit;

    assign zero_bit = bit_vld && !mark;
    assign set_hit  = zero_bit && (zrun_q >= SET_LAST);
    assign long_run = zero_bit && (zrun_q >= CLR_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            zrun_q <= '0;
        end else if (bit_vld) begin
            if (mark) begin
                zrun_q <= '0;
            end else if (zrun_q != SAT_VAL) begin
                zrun_q <= zrun_q + 1'b1;
            end
        end
    end

    // R2
    mark_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && mark) |=> (zrun_q == '0));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |=> $stable(zrun_q));

endmodule

// File: rtl/e1los_density_win.sv
module e1los_density_win
    import e1los_pkg::*;
#(
    parameter int unsigned WIN_LEN = DEF_WIN_LEN,
    parameter int unsigned WIN_MIN = DEF_WIN_MIN
) (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic bit_vld,
    input  logic mark,
    input  logic long_run,
    output logic win_pass
);
    localparam int unsigned PW = cnt_w(WIN_LEN - 1);
    localparam int unsigned OW = cnt_w(WIN_MIN);
    localparam logic [PW-1:0] POS_LAST = PW'(WIN_LEN - 1);
    localparam logic [OW-1:0] ONES_OK  = OW'(WIN_MIN);

    logic [PW-1:0] pos_q;
    logic [OW-1:0] ones_q;
    logic [OW-1:0] ones_nx;
    logic          spoil_q;
    logic          last_bit;

    assign last_bit = (pos_q == POS_LAST);
    assign ones_nx  = (mark && (ones_q != ONES_OK)) ? ones_q + 1'b1 : ones_q;
    assign win_pass = armed && bit_vld && last_bit
                   && (ones_nx == ONES_OK) && !spoil_q && !long_run;

    always_ff @(posedge clk) begin
        if (rst || !armed) begin
            pos_q   <= '0;
            ones_q  <= '0;
            spoil_q <= 1'b0;
        end else if (bit_vld) begin
            if (last_bit) begin
                pos_q   <= '0;
                ones_q  <= '0;
                spoil_q <= 1'b0;
            end else begin
                pos_q   <= pos_q + 1'b1;
                ones_q  <= ones_nx;
                spoil_q <= spoil_q || long_run;
            end
        end
    end

    // R5
    long_run_block_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && long_run) |=> !win_pass);

    // R12
    idle_window_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !bit_vld) |=> $stable(pos_q));

endmodule

// File: rtl/e1los_rx_gate.sv
module e1los_rx_gate
    import e1los_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bit_vld,
    input  logic    pos_i,
    input  logic    neg_i,
    input  logic    los,
    input  logic    hold,
    output rx_sym_t sym_q
);
    rx_sym_t sym_d;

    always_comb begin
        if (los && !hold) begin
            sym_d = sym_idle();
        end else begin
            sym_d.pos = pos_i && bit_vld;
            sym_d.neg = neg_i && bit_vld;
            sym_d.stb = bit_vld;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_q <= sym_idle();
        end else begin
            sym_q <= sym_d;
        end
    end

    // R9
    forced_low_chk: assert property (@(posedge clk) disable iff (rst)
        (los && !hold) |=> (sym_q == sym_idle()));

    // R10
    strobe_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && (hold || !los)) |=> sym_q.stb);

endmodule

// File: rtl/e1_los_detector.sv
module e1_los_detector
    import e1los_pkg::*;
#(
    parameter int unsigned SET_RUN = DEF_SET_RUN,
    parameter int unsigned CLR_RUN = DEF_CLR_RUN,
    parameter int unsigned WIN_LEN = DEF_WIN_LEN,
    parameter int unsigned WIN_MIN = DEF_WIN_MIN
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic rx_pos_i,
    input  logic rx_neg_i,
    input  logic alos_i,
    input  logic pwr_down_i,
    input  logic mclk_lost_i,
    input  logic rx_hold_i,
    output logic los_o,
    output logic rx_pos_o,
    output logic rx_neg_o,
    output logic rx_stb_o
);
    logic    mark;
    logic    set_hit;
    logic    long_run;
    logic    win_pass;
    logic    armed;
    link_e   link_q;
    rx_sym_t sym;

    assign mark  = rx_pos_i || rx_neg_i;
    assign armed = (link_q == LINK_LOST);

    e1los_zero_run #(
        .SET_RUN (SET_RUN),
        .CLR_RUN (CLR_RUN)
    ) u_zrun (
        .clk      (clk),
        .rst      (rst),
        .bit_vld  (bit_vld),
        .mark     (mark),
        .set_hit  (set_hit),
        .long_run (long_run)
    );

    e1los_density_win #(
        .WIN_LEN (WIN_LEN),
        .WIN_MIN (WIN_MIN)
    ) u_win (
        .clk      (clk),
        .rst      (rst),
        .armed    (armed),
        .bit_vld  (bit_vld),
        .mark     (mark),
        .long_run (long_run),
        .win_pass (win_pass)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            link_q <= LINK_LOST;
        end else if (set_hit) begin
            link_q <= LINK_LOST;
        end else if (win_pass) begin
            link_q <= LINK_OK;
        end
    end

    assign los_o = armed || alos_i || pwr_down_i || mclk_lost_i;

    e1los_rx_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .bit_vld (bit_vld),
        .pos_i   (rx_pos_i),
        .neg_i   (rx_neg_i),
        .los     (los_o),
        .hold    (rx_hold_i),
        .sym_q   (sym)
    );

    assign rx_pos_o = sym.pos;
    assign rx_neg_o = sym.neg;
    assign rx_stb_o = sym.stb;

    // R8
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (armed && !rx_pos_o && !rx_neg_o && !rx_stb_o));

    // R3
    clear_on_bit_chk: assert property (@(posedge clk) disable iff (rst)
        ((link_q == LINK_OK) && $past(link_q == LINK_LOST)) |-> $past(bit_vld));

    // R1
    set_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((link_q == LINK_LOST) && $past(link_q == LINK_OK)) |-> $past(bit_vld && !mark));

endmodule

// File: tb/e1_los_detector_test.sv
`timescale 1ns/100ps
module e1_los_detector_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_vld = 1'b0;
    logic rx_pos_i = 1'b0;
    logic rx_neg_i = 1'b0;
    logic alos_i = 1'b0;
    logic pwr_down_i = 1'b0;
    logic mclk_lost_i = 1'b0;
    logic rx_hold_i = 1'b0;
    logic los_o, rx_pos_o, rx_neg_o, rx_stb_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    e1_los_detector uut (
        .clk         (clk),
        .rst         (rst),
        .bit_vld     (bit_vld),
        .rx_pos_i    (rx_pos_i),
        .rx_neg_i    (rx_neg_i),
        .alos_i      (alos_i),
        .pwr_down_i  (pwr_down_i),
        .mclk_lost_i (mclk_lost_i),
        .rx_hold_i   (rx_hold_i),
        .los_o       (los_o),
        .rx_pos_o    (rx_pos_o),
        .rx_neg_o    (rx_neg_o),
        .rx_stb_o    (rx_stb_o)
    );

    // {vld, pos, neg, alos, pd, mclk_lost, hold, exp_los, exp_pos, exp_neg, exp_stb}
    localparam logic [10:0] VEC [10] = '{
        11'b1_1_0_0_0_0_0_0_1_0_1,
        11'b1_0_1_0_0_0_0_0_0_1_1,
        11'b0_1_0_0_0_0_0_0_0_0_0,
        11'b1_1_0_1_0_0_0_1_0_0_0,
        11'b1_0_1_1_0_0_1_1_0_1_1,
        11'b1_1_0_0_1_0_0_1_0_0_0,
        11'b1_1_0_0_0_1_0_1_0_0_0,
        11'b1_1_0_0_0_1_1_1_1_0_1,
        11'b1_0_1_0_0_0_1_0_0_1_1,
        11'b1_1_0_1_1_1_0_1_0_0_0
    };

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic send(input logic p, input logic n);
        bit_vld  = 1'b1;
        rx_pos_i = p;
        rx_neg_i = n;
        @(posedge clk);
        #1;
        bit_vld  = 1'b0;
        rx_pos_i = 1'b0;
        rx_neg_i = 1'b0;
    endtask

    task automatic zeros(input int cnt);
        for (int i = 0; i < cnt; i++) send(1'b0, 1'b0);
    endtask

    // sends bits 0..upto-1 of a window; marks alternate rails
    task automatic send_win(input logic [31:0] mask, input int upto);
        bit rail;
        rail = 1'b0;
        for (int i = 0; i < upto; i++) begin
            if (mask[i]) begin
                send(!rail, rail);
                rail = !rail;
            end else begin
                send(1'b0, 1'b0);
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #800000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] win4;
        win4 = 32'h8080_8080;
        repeat (3) @(posedge clk);
        #1;
        // R8: reset state
        chk("R8 reset", {los_o, rx_pos_o, rx_neg_o, rx_stb_o}, 4'b1000);
        rst = 1'b0;

        // R3, R11: window of 4 marks (both rails) clears only on last bit
        send_win(win4, 31);
        chk("R3 31 bits", {3'b0, los_o}, 4'b0001);
        send(1'b0, 1'b1);
        chk("R3 R11 clear", {3'b0, los_o}, 4'b0000);

        // R6 R7 R9 R10: vector table
        foreach (VEC[k]) begin
            bit_vld     = VEC[k][10];
            rx_pos_i    = VEC[k][9];
            rx_neg_i    = VEC[k][8];
            alos_i      = VEC[k][7];
            pwr_down_i  = VEC[k][6];
            mclk_lost_i = VEC[k][5];
            rx_hold_i   = VEC[k][4];
            #1;
            chk("R6 R7 los vec", {3'b0, los_o}, {3'b0, VEC[k][3]});
            @(posedge clk);
            #1;
            chk("R9 R10 rx vec", {1'b0, rx_pos_o, rx_neg_o, rx_stb_o}, {1'b0, VEC[k][2:0]});
        end
        bit_vld = 0; rx_pos_i = 0; rx_neg_i = 0; alos_i = 0;
        pwr_down_i = 0; mclk_lost_i = 0; rx_hold_i = 0;

        // R1: 174 zeros hold, 175th sets
        zeros(174);
        chk("R1 174 zeros", {3'b0, los_o}, 4'b0000);
        zeros(1);
        chk("R1 175 zeros", {3'b0, los_o}, 4'b0001);

        // R5: dense window but first bit extends a long run
        send_win(win4, 32);
        chk("R5 long run", {3'b0, los_o}, 4'b0001);

        // R4: only three marks
        send_win(32'h0000_8081, 32);
        chk("R4 three marks", {3'b0, los_o}, 4'b0001);

        // R3 with analog flag in the same cycle as the digital clear
        alos_i = 1'b1;
        send_win(win4, 32);
        chk("R6 alos holds", {3'b0, los_o}, 4'b0001);
        alos_i = 1'b0;
        #1;
        chk("R3 cleared under alos", {3'b0, los_o}, 4'b0000);

        // R2: mark restarts the run
        zeros(174);
        send(1'b1, 1'b0);
        zeros(174);
        chk("R2 split runs", {3'b0, los_o}, 4'b0000);

        // R12: idle cycles do not count
        repeat (40) @(posedge clk);
        #1;
        chk("R12 idle", {3'b0, los_o}, 4'b0000);
        zeros(1);
        chk("R12 R1 run resumes", {3'b0, los_o}, 4'b0001);

        // R9: digital alarm gates data; R10: hold passes it
        send(1'b1, 1'b0);
        chk("R9 gated", {1'b0, rx_pos_o, rx_neg_o, rx_stb_o}, 4'b0000);
        rx_hold_i = 1'b1;
        send(1'b1, 1'b0);
        chk("R10 hold", {1'b0, rx_pos_o, rx_neg_o, rx_stb_o}, 4'b0101);

        // R8: reset with live data and hold
        rst = 1'b1;
        send(1'b0, 1'b1);
        chk("R8 mid reset", {los_o, rx_pos_o, rx_neg_o, rx_stb_o}, 4'b1000);
        rst = 1'b0;
        rx_hold_i = 1'b0;

        finish_run();
    end

endmodule